// File: doc/BRIEF.md
# CPU-Space Breakpoint and Coprocessor Responder

This block sits beside a processor bus and answers the special cycles the processor issues in its CPU address space. It is identified by the function code `3'b111` together with the address strobe. Two kinds of cycle are claimed, picked by the space type in address bits 19:16. A breakpoint-acknowledge cycle (type 0) asks for a replacement instruction word for one of eight breakpoint numbers. The responder returns the word a debugger armed for that number, or a bus error when nothing is armed. A coprocessor cycle (type 2) carries a coprocessor ID and an interface-register select. The responder turns these into a one-hot chip select for coprocessors 1 to 7. It then relays the selected coprocessor's acknowledge, or raises a bus error after a programmable wait.

A host-side write port loads the eight 16-bit instruction words and their armed flags. Two mode inputs shape breakpoint service. In byte-port mode the word goes out in two successive cycles, high byte first, each with a byte acknowledge. In one-shot mode an entry is disarmed once its word has been fully handed over. ID 0 in a coprocessor cycle belongs to memory-management traffic and is never claimed.

Top module: `cpsp_responder`

## Requirements
- R1: After reset, all response outputs, `rsp_data` and `cp_sel` are zero, and every breakpoint entry is unarmed.
- R2: `cp_sel` has bit N set (N = 1..7, nothing else set) and `cp_regsel` equals A4:A0 exactly while `bus_strobe` is high, `bus_fc` is 3'b111, A19:A16 is 4'h2 and A15:A13 is N. In every other case both are zero.
- R3: A breakpoint cycle (A19:A16 = 4'h0, number in A4:A2) to an armed entry in word mode sets `rsp_data` to the stored word and raises `rsp_ack_word` after the first clock edge that samples the cycle. Both hold unchanged while the cycle stays live.
- R4: A breakpoint cycle to an unarmed entry raises `rsp_berr` with no acknowledge and `rsp_data` zero. At most one of the three response outputs is ever high.
- R5: In byte-port mode the first cycle returns the high byte in `rsp_data[7:0]` and the next breakpoint cycle returns the low byte, whatever its number. Each beat is acknowledged with `rsp_ack_byte`, and `rsp_data[15:8]` stays zero.
- R6: With `one_shot_mode` high, an entry is disarmed at the beat that completes its word. With it low, the entry stays armed.
- R7: In a claimed coprocessor cycle, an acknowledge on the selected coprocessor's `cp_ack` bit, sampled at an edge after the claiming edge, raises `rsp_ack_word` after that edge. Acknowledges on other bits are ignored.
- R8: If no qualifying acknowledge is sampled within max(L,1) edges after the claiming edge (L = `ack_timeout`), `rsp_berr` rises after edge claim+max(L,1). An acknowledge and the timeout on the same edge resolve to the acknowledge.
- R9: A coprocessor cycle with ID 0, a CPU-space cycle of any type other than 0 or 2, and a strobe with a non-CPU function code all leave every response output low.
- R10: A host write (`host_we`) stores `host_word` and the armed flag `host_arm` in entry `host_idx` at the clock edge. Writing with `host_arm` low disarms the entry, so its next breakpoint cycle takes a bus error.
- R11: The first edge that samples the cycle not live (strobe low or function code not CPU) clears all response outputs and `rsp_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_strobe | input | 1 | Address strobe, high while a bus cycle is live |
| bus_fc | input | 3 | Function code; 3'b111 marks CPU space |
| bus_addr | input | 20 | Address bits 19:0 of the cycle |
| byte_port_mode | input | 1 | Serve breakpoint words as two byte beats |
| one_shot_mode | input | 1 | Disarm an entry after its word is delivered |
| ack_timeout | input | 8 | Coprocessor acknowledge wait limit in clocks |
| host_we | input | 1 | Host write strobe |
| host_idx | input | 3 | Breakpoint entry written |
| host_word | input | 16 | Instruction word written |
| host_arm | input | 1 | Armed flag written with the word |
| cp_ack | input | 7 | Acknowledge from coprocessors 1..7 (bit index = ID) |
| cp_sel | output | 7 | One-hot coprocessor select, bit index = ID |
| cp_regsel | output | 5 | Interface-register select for the selected coprocessor |
| rsp_data | output | 16 | Word or byte returned to the processor |
| rsp_ack_word | output | 1 | Word acknowledge to the processor |
| rsp_ack_byte | output | 1 | Byte acknowledge to the processor |
| rsp_berr | output | 1 | Bus error to the processor |

## Verification
The chip select and register select are combinational, so they are checked at the falling edge right after the address is driven. Breakpoint answers and quiet outcomes are due one rising edge after the cycle goes live. A relayed coprocessor acknowledge raised after d edges is due at claim+d+1, and a timeout at claim+max(L,1). The bench drives every input at a falling edge. It then counts rising edges explicitly: it checks that the responses stay low before their due edge and samples them at the falling edge after it. Release is checked one edge after the strobe is dropped.

// File: rtl/cpsp_pkg.sv
package cpsp_pkg;

  localparam int          AW      = 20;
  localparam int          NBP     = 8;
  localparam int          NCP     = 7;
  localparam logic [2:0]  FC_CPU  = 3'b111;
  localparam logic [3:0]  T_BKPT  = 4'h0;
  localparam logic [3:0]  T_COPRO = 4'h2;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HOLD} rsp_state_e;

  function automatic logic [3:0] space_type(input logic [AW-1:0] a);
    return a[19:16];
  endfunction

  function automatic logic [2:0] bkpt_num(input logic [AW-1:0] a);
    return a[4:2];
  endfunction

  function automatic logic [2:0] copro_id(input logic [AW-1:0] a);
    return a[15:13];
  endfunction

  function automatic logic [4:0] copro_reg(input logic [AW-1:0] a);
    return a[4:0];
  endfunction

  function automatic logic [NCP:1] id_onehot(input logic [2:0] id);
    logic [NCP:1] r;
    r = '0;
    for (int i = 1; i <= NCP; i++) begin
      if (id == 3'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/cpsp_bkpt_store.sv
module cpsp_bkpt_store #(
  parameter int WW = 16,
  parameter int NE = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [$clog2(NE)-1:0] wr_idx,
  input  logic [WW-1:0]         wr_word,
  input  logic                  wr_arm,
  input  logic [$clog2(NE)-1:0] rd_idx,
  output logic [WW-1:0]         rd_word,
  output logic                  rd_valid,
  input  logic                  use_en,
  input  logic [$clog2(NE)-1:0] use_idx
);
  localparam int IW = $clog2(NE);

  logic [WW-1:0] words [NE];
  logic [NE-1:0] armed;

  for (genvar g = 0; g < NE; g++) begin : g_entry
    logic [WW-1:0] w_q;
    logic          v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q <= '0;
        v_q <= 1'b0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        w_q <= wr_word;
        v_q <= wr_arm;
      end else if (use_en && use_idx == IW'(g)) begin
        v_q <= 1'b0;
      end
    end
    assign words[g] = w_q;
    assign armed[g] = v_q;
  end

  assign rd_word  = words[rd_idx];
  assign rd_valid = armed[rd_idx];

endmodule

// File: rtl/cpsp_cp_router.sv
module cpsp_cp_router
  import cpsp_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live,
  input  logic [3:0]    sp_type,
  input  logic [2:0]    id,
  input  logic [4:0]    regsel_in,
  input  logic [NCP:1]  cp_ack,
  input  logic          waiting,
  input  logic [TW-1:0] limit,
  output logic [NCP:1]  cp_sel,
  output logic [4:0]    cp_regsel,
  output logic          ack_hit,
  output logic          timed_out
);
  logic [TW-1:0] cnt;
  logic          claim;

  assign claim     = live && (sp_type == T_COPRO) && (id != 3'd0);
  assign cp_sel    = claim ? id_onehot(id) : '0;
  assign cp_regsel = claim ? regsel_in : '0;
  assign ack_hit   = |(cp_ack & cp_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!waiting) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign timed_out = waiting &&
                     (((TW+1)'(cnt) + (TW+1)'(1)) >= (TW+1)'(limit));

endmodule

// File: rtl/cpsp_responder.sv
module cpsp_responder
  import cpsp_pkg::*;
#(
  parameter int WW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_strobe,
  input  logic [2:0]    bus_fc,
  input  logic [19:0]   bus_addr,
  input  logic          byte_port_mode,
  input  logic          one_shot_mode,
  input  logic [TW-1:0] ack_timeout,
  input  logic          host_we,
  input  logic [2:0]    host_idx,
  input  logic [WW-1:0] host_word,
  input  logic          host_arm,
  input  logic [7:1]    cp_ack,
  output logic [7:1]    cp_sel,
  output logic [4:0]    cp_regsel,
  output logic [WW-1:0] rsp_data,
  output logic          rsp_ack_word,
  output logic          rsp_ack_byte,
  output logic          rsp_berr
);
  localparam int HB = WW / 2;

  rsp_state_e    st;
  logic          cyc_live, at_idle, in_wait;
  logic          ack_hit, timed_out;
  logic [3:0]    typ;
  logic [2:0]    bp, cid;
  logic [WW-1:0] rd_word;
  logic          rd_valid;
  logic          pend;
  logic [WW-1:0] hold;
  logic [2:0]    pidx;
  logic          bp_take;
  logic [2:0]    take_idx;
  logic          unused_addr_bits;

  assign cyc_live         = bus_strobe && (bus_fc == FC_CPU);
  assign at_idle          = (st == ST_IDLE);
  assign in_wait          = (st == ST_WAIT);
  assign typ              = space_type(bus_addr);
  assign bp               = bkpt_num(bus_addr);
  assign cid              = copro_id(bus_addr);
  assign unused_addr_bits = ^bus_addr[12:5];

  // final beat of a breakpoint word: disarm in one-shot mode
  assign bp_take  = one_shot_mode && at_idle && cyc_live && (typ == T_BKPT) &&
                    (pend || (rd_valid && !byte_port_mode));
  assign take_idx = pend ? pidx : bp;

  cpsp_bkpt_store #(.WW(WW), .NE(NBP)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_we),
    .wr_idx   (host_idx),
    .wr_word  (host_word),
    .wr_arm   (host_arm),
    .rd_idx   (bp),
    .rd_word  (rd_word),
    .rd_valid (rd_valid),
    .use_en   (bp_take),
    .use_idx  (take_idx)
  );

  cpsp_cp_router #(.TW(TW)) u_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .live      (cyc_live),
    .sp_type   (typ),
    .id        (cid),
    .regsel_in (copro_reg(bus_addr)),
    .cp_ack    (cp_ack),
    .waiting   (in_wait),
    .limit     (ack_timeout),
    .cp_sel    (cp_sel),
    .cp_regsel (cp_regsel),
    .ack_hit   (ack_hit),
    .timed_out (timed_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      rsp_data     <= '0;
      rsp_ack_word <= 1'b0;
      rsp_ack_byte <= 1'b0;
      rsp_berr     <= 1'b0;
      pend         <= 1'b0;
      hold         <= '0;
      pidx         <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cyc_live) begin
            st <= ST_HOLD;
            if (typ == T_BKPT) begin
              if (pend) begin
                rsp_data     <= WW'(hold[HB-1:0]);
                rsp_ack_byte <= 1'b1;
                pend         <= 1'b0;
              end else if (rd_valid) begin
                if (byte_port_mode) begin
                  rsp_data     <= WW'(rd_word[WW-1:HB]);
                  rsp_ack_byte <= 1'b1;
                  pend         <= 1'b1;
                  hold         <= rd_word;
                  pidx         <= bp;
                end else begin
                  rsp_data     <= rd_word;
                  rsp_ack_word <= 1'b1;
                end
              end else begin
                rsp_berr <= 1'b1;
              end
            end else if (typ == T_COPRO && cid != 3'd0) begin
              st <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (!cyc_live) begin
            st <= ST_IDLE;
          end else if (ack_hit) begin
            rsp_ack_word <= 1'b1;
            st           <= ST_HOLD;
          end else if (timed_out) begin
            rsp_berr <= 1'b1;
            st       <= ST_HOLD;
          end
        end
        default: begin
          if (!cyc_live) begin
            st           <= ST_IDLE;
            rsp_data     <= '0;
            rsp_ack_word <= 1'b0;
            rsp_ack_byte <= 1'b0;
            rsp_berr     <= 1'b0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cpsp_chk.sv
module cpsp_chk
  import cpsp_pkg::*;
#(
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_strobe,
  input logic [2:0]    bus_fc,
  input logic [19:0]   bus_addr,
  input logic [7:1]    cp_sel,
  input logic [WW-1:0] rsp_data,
  input logic          rsp_ack_word,
  input logic          rsp_ack_byte,
  input logic          rsp_berr,
  input logic          cyc_live,
  input logic          at_idle,
  input logic          in_wait,
  input logic          ack_hit,
  input logic          timed_out
);
  logic any_rsp;
  assign any_rsp = rsp_ack_word || rsp_ack_byte || rsp_berr;

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cp_sel));

  assert_sel_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_sel != '0) |-> (bus_strobe && bus_fc == FC_CPU &&
                        space_type(bus_addr) == T_COPRO &&
                        copro_id(bus_addr) != 3'd0));

  assert_rsp_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_ack_word, rsp_ack_byte, rsp_berr}));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_rsp && cyc_live) |=>
      $stable({rsp_data, rsp_ack_word, rsp_ack_byte, rsp_berr}));

  assert_relay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && cyc_live && ack_hit) |=> (rsp_ack_word && !rsp_berr));

  assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && cyc_live && timed_out && !ack_hit) |=> (rsp_berr && !rsp_ack_word));

  assert_id0_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (at_idle && cyc_live && space_type(bus_addr) == T_COPRO &&
     copro_id(bus_addr) == 3'd0) |=> !any_rsp);

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_live |=> (!any_rsp && rsp_data == '0));

endmodule

bind cpsp_responder cpsp_chk #(.WW(WW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_strobe   (bus_strobe),
  .bus_fc       (bus_fc),
  .bus_addr     (bus_addr),
  .cp_sel       (cp_sel),
  .rsp_data     (rsp_data),
  .rsp_ack_word (rsp_ack_word),
  .rsp_ack_byte (rsp_ack_byte),
  .rsp_berr     (rsp_berr),
  .cyc_live     (cyc_live),
  .at_idle      (at_idle),
  .in_wait      (in_wait),
  .ack_hit      (ack_hit),
  .timed_out    (timed_out)
);

// File: tb/tb_cpsp_responder.sv
module tb_cpsp_responder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_strobe = 1'b0;
  logic [2:0]  bus_fc = 3'b000;
  logic [19:0] bus_addr = '0;
  logic        byte_port_mode = 1'b0;
  logic        one_shot_mode = 1'b0;
  logic [7:0]  ack_timeout = 8'd4;
  logic        host_we = 1'b0;
  logic [2:0]  host_idx = '0;
  logic [15:0] host_word = '0;
  logic        host_arm = 1'b0;
  logic [7:1]  cp_ack = '0;
  logic [7:1]  cp_sel;
  logic [4:0]  cp_regsel;
  logic [15:0] rsp_data;
  logic        rsp_ack_word, rsp_ack_byte, rsp_berr;

  int n_chk = 0;
  int n_err = 0;

  logic [15:0] m_word [8];
  bit          m_valid [8];
  bit          m_pend = 0;
  logic [15:0] m_hold = '0;
  int          m_pidx = 0;

  always #5 clk = ~clk;

  cpsp_responder dut (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_fc(bus_fc),
    .bus_addr(bus_addr), .byte_port_mode(byte_port_mode),
    .one_shot_mode(one_shot_mode), .ack_timeout(ack_timeout),
    .host_we(host_we), .host_idx(host_idx), .host_word(host_word),
    .host_arm(host_arm), .cp_ack(cp_ack), .cp_sel(cp_sel),
    .cp_regsel(cp_regsel), .rsp_data(rsp_data), .rsp_ack_word(rsp_ack_word),
    .rsp_ack_byte(rsp_ack_byte), .rsp_berr(rsp_berr)
  );

  function automatic logic [6:0] exp_sel(int id);
    return (id == 0) ? 7'd0 : 7'(1 << (id - 1));
  endfunction

  function automatic logic [2:0] rsp_vec();
    return {rsp_ack_word, rsp_ack_byte, rsp_berr};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic release_cycle();
    bus_strobe = 1'b0;
    @(negedge clk);
    chk("R11 release responses", 32'(rsp_vec()), 32'd0);
    chk("R11 release data", 32'(rsp_data), 32'd0);
    chk("R2 no select when idle", 32'(cp_sel), 32'd0);
  endtask

  task automatic host_wr(int idx, logic [15:0] w, bit arm);
    host_we = 1'b1; host_idx = idx[2:0]; host_word = w; host_arm = arm;
    @(negedge clk);
    host_we = 1'b0;
    m_word[idx] = w;
    m_valid[idx] = arm;
  endtask

  task automatic bp_cycle(int n, int extra);
    logic [15:0] ed;
    logic [2:0]  ev;
    bit          fin;
    int          cidx;
    string       tag;
    fin = 0; cidx = n; ed = '0;
    if (m_pend) begin
      ed = {8'h00, m_hold[7:0]}; ev = 3'b010; fin = 1; cidx = m_pidx; m_pend = 0;
      tag = "R5 low byte beat";
    end else if (m_valid[n]) begin
      if (byte_port_mode) begin
        ed = {8'h00, m_word[n][15:8]}; ev = 3'b010;
        m_pend = 1; m_hold = m_word[n]; m_pidx = n;
        tag = "R5 high byte beat";
      end else begin
        ed = m_word[n]; ev = 3'b100; fin = 1;
        tag = "R3 word answer";
      end
    end else begin
      ev = 3'b001;
      tag = "R4 unarmed bus error";
    end
    bus_strobe = 1'b1; bus_fc = 3'b111;
    bus_addr = {4'h0, 11'($urandom), n[2:0], 2'($urandom)};
    @(negedge clk);
    chk({tag, " responses"}, 32'(rsp_vec()), 32'(ev));
    chk({tag, " data"}, 32'(rsp_data), 32'(ed));
    chk("R2 no select on breakpoint", 32'(cp_sel), 32'd0);
    for (int k = 0; k < extra; k++) begin
      @(negedge clk);
      chk("R3 held while live", 32'({rsp_vec(), rsp_data}), 32'({ev, ed}));
    end
    release_cycle();
    if (fin && one_shot_mode) m_valid[cidx] = 0;
  endtask

  task automatic cp_cycle(int id, int d, int lim, bit wrong);
    int   lmax, resp, other;
    bit   good;
    logic [4:0] rs;
    rs = 5'($urandom);
    ack_timeout = 8'(lim);
    bus_strobe = 1'b1; bus_fc = 3'b111;
    bus_addr = {4'h2, id[2:0], 8'($urandom), rs};
    @(negedge clk);
    chk("R2 chip select", 32'(cp_sel), 32'(exp_sel(id)));
    chk("R2 register select", 32'(cp_regsel), (id == 0) ? 32'd0 : 32'(rs));
    chk("R9 no early response", 32'(rsp_vec()), 32'd0);
    if (id == 0) begin
      @(negedge clk);
      chk("R9 id zero stays quiet", 32'(rsp_vec()), 32'd0);
      release_cycle();
      return;
    end
    lmax = (lim < 1) ? 1 : lim;
    good = !wrong && (d + 1 <= lmax);
    resp = good ? d + 1 : lmax;
    other = (id % 7) + 1;
    for (int k = 0; k < resp; k++) begin
      if (k == d) cp_ack = wrong ? exp_sel(other) : exp_sel(id);
      @(negedge clk);
      if (k + 1 < resp) chk("R8 no response before due edge", 32'(rsp_vec()), 32'd0);
    end
    if (good) chk("R7 relayed acknowledge", 32'(rsp_vec()), 32'b100);
    else      chk("R8 timeout bus error", 32'(rsp_vec()), 32'b001);
    cp_ack = '0;
    release_cycle();
  endtask

  task automatic other_cycle(logic [2:0] fcv, logic [3:0] typ);
    bus_strobe = 1'b1; bus_fc = fcv;
    bus_addr = {typ, 16'($urandom)};
    @(negedge clk);
    chk("R9 unclaimed cycle quiet", 32'(rsp_vec()), 32'd0);
    chk("R2 unclaimed no select", 32'(cp_sel), 32'd0);
    release_cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5EED_0042);
    for (int i = 0; i < 8; i++) begin m_word[i] = '0; m_valid[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 reset responses", 32'(rsp_vec()), 32'd0);
    chk("R1 reset select", 32'(cp_sel), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: no entry armed after reset
    for (int i = 0; i < 8; i++) bp_cycle(i, 0);
    // R10 / R3: arm, word answer, held
    host_wr(5, 16'hA55A, 1);
    bp_cycle(5, 2);
    // R6: not one-shot keeps entry armed
    bp_cycle(5, 0);
    one_shot_mode = 1'b1;
    bp_cycle(5, 0);
    bp_cycle(5, 0);
    one_shot_mode = 1'b0;
    // R5: byte beats, second cycle with a different number
    byte_port_mode = 1'b1;
    host_wr(2, 16'h1234, 1);
    bp_cycle(2, 1);
    bp_cycle(6, 0);
    byte_port_mode = 1'b0;
    // R10: disarm
    host_wr(2, 16'hBEEF, 0);
    bp_cycle(2, 0);
    // R7 / R8 / R9 directed
    cp_cycle(3, 2, 5, 0);
    cp_cycle(7, 0, 5, 1);
    cp_cycle(1, 4, 0, 0);
    cp_cycle(4, 3, 4, 0);
    cp_cycle(0, 0, 3, 0);
    other_cycle(3'b111, 4'h1);
    other_cycle(3'b101, 4'h2);
    other_cycle(3'b001, 4'h0);
    for (int it = 0; it < 300; it++) begin
      case ($urandom % 7)
        0: host_wr(int'($urandom % 8), 16'($urandom), ($urandom % 4) != 0);
        1, 2: bp_cycle(int'($urandom % 8), int'($urandom % 3));
        3, 4: cp_cycle(int'($urandom % 8), int'($urandom % 9),
                       int'($urandom % 7), ($urandom % 5) == 0);
        5: begin
          byte_port_mode = 1'($urandom);
          one_shot_mode  = 1'($urandom);
          @(negedge clk);
        end
        default: other_cycle(3'b111, (($urandom % 2) != 0) ? 4'h3 : 4'hF);
      endcase
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule